// File: doc/BRIEF.md
# Quadrature-Lock Delay Loop Controller

This block is the digital core of a delay-locked loop. The loop lines up a data-capture clock with a reference toggle bit that comes back from an external data source. The block derives a quarter-rate clock from the sample clock. It samples the returned reference bit at two fixed offsets inside each quarter-rate period. The two samples form a 2-bit quadrant code, which yields one up or down phase decision per period.

A run-length filter turns the decisions into single steps of a delay tap index. The index has an asymmetric range: there is far more room to add delay than to remove it, measured from the nominal position. Lock is declared once the decisions have dithered about the quadrature point for long enough.

An invert control moves the stable point from a quarter to three quarters of the reference period. It does this by swapping the add and subtract zones and inverting the quarter-rate clock. A restart control parks the index at its nominal value and ignores the reference, so that fixed external timing can be used instead.

Top module: `dll_quad_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `tap_code` equals NEG_TAPS (the nominal index) and `locked` is 0.
- R2: `qclk` is bit 1 of a free-running 2-bit phase counter that starts at 0 at reset release, giving a period of 4 clocks. `qclk` is XORed with `inv_clk`. Restart does not affect it.
- R3: `ref_bit` is sampled on the clock edge at phase 0 and on the edge at phase 1. These form the quadrant code {sample0, sample1}, and one decision is made on the phase-1 edge. Codes 2'b11 and 2'b10 request more delay and codes 2'b01 and 2'b00 request less. With `inv_clk` high the meanings are swapped.
- R4: The tap index moves by exactly one step, only when AGREE_N consecutive decisions agree. The agreement count then restarts from zero, and any disagreeing decision restarts the count at one.
- R5: The index saturates at 0 and at NEG_TAPS+POS_TAPS and never wraps. The nominal index NEG_TAPS leaves a smaller range below it than above it.
- R6: A step that is blocked by saturation clears `locked` and the alternation count.
- R7: `locked` rises on the decision that completes LOCK_M consecutive decisions, each opposite to the one before it. It then stays high until restart or a saturation event.
- R8: While `restart` is high, the index is forced to NEG_TAPS, `locked` is held low, the filter state is cleared and `ref_bit` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Hold loop at nominal tap, ignore reference |
| inv_clk | input | 1 | Move the lock point to 3T/4 and invert the quarter-rate clock |
| ref_bit | input | 1 | Returned reference toggle bit |
| tap_code | output | $clog2(NEG_TAPS+POS_TAPS+1) | Delay tap index, nominal at NEG_TAPS |
| locked | output | 1 | Loop lock flag |
| qclk | output | 1 | Internal quarter-rate clock phase |

## Verification
The bench builds the block with NEG_TAPS=4, POS_TAPS=12, AGREE_N=3 and LOCK_M=4. The whole index range is then 16 steps, so both saturation ends can be reached within a few dozen quarter-rate periods. A lock needs only four dithering decisions, so lock, loss of lock through saturation and restart recovery all recur many times under random phase, invert and restart patterns. The short agreement run also lets disagreeing decisions often interrupt a run just before a step.

// File: rtl/dll_quad_ctrl.sv
module dll_quad_ctrl #(
  parameter int NEG_TAPS = 8,
  parameter int POS_TAPS = 32,
  parameter int AGREE_N  = 4,
  parameter int LOCK_M   = 8,
  localparam int TAP_MAX = NEG_TAPS + POS_TAPS,
  localparam int TW      = $clog2(TAP_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          inv_clk,
  input  logic          ref_bit,
  output logic [TW-1:0] tap_code,
  output logic          locked,
  output logic          qclk
);
  localparam int CW = $clog2(AGREE_N + 1);
  localparam int LW = $clog2(LOCK_M + 1);
  localparam logic [TW-1:0] TAP_NOM = TW'(NEG_TAPS);
  localparam logic [TW-1:0] TAP_TOP = TW'(TAP_MAX);

  logic [1:0]    ph;
  logic          samp0;
  logic [1:0]    quad;
  logic          raw_up, want_up;
  logic [CW-1:0] run_cnt, run_next;
  logic          run_dir, last_dir, have_last;
  logic [LW-1:0] alt_cnt;
  logic          step_now, sat_hit, alternate;
  logic [TW-1:0] tap;
  logic          lock_q;

  assign quad = {samp0, ref_bit};

  always_comb begin
    case (quad)
      2'b11, 2'b10: raw_up = 1'b1;
      default:      raw_up = 1'b0;
    endcase
  end

  assign want_up   = raw_up ^ inv_clk;
  assign run_next  = (run_cnt != '0 && run_dir == want_up) ? run_cnt + 1'b1 : CW'(1);
  assign step_now  = (run_next == CW'(AGREE_N));
  assign sat_hit   = step_now && (want_up ? (tap == TAP_TOP) : (tap == '0));
  assign alternate = have_last && (want_up != last_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= '0;
      samp0     <= 1'b0;
      tap       <= TAP_NOM;
      run_cnt   <= '0;
      run_dir   <= 1'b0;
      last_dir  <= 1'b0;
      have_last <= 1'b0;
      alt_cnt   <= '0;
      lock_q    <= 1'b0;
    end else begin
      ph <= ph + 2'd1;
      if (ph == 2'd0) samp0 <= ref_bit;
      if (restart) begin
        tap       <= TAP_NOM;
        run_cnt   <= '0;
        run_dir   <= 1'b0;
        last_dir  <= 1'b0;
        have_last <= 1'b0;
        alt_cnt   <= '0;
        lock_q    <= 1'b0;
      end else if (ph == 2'd1) begin
        run_cnt   <= step_now ? '0 : run_next;
        run_dir   <= want_up;
        last_dir  <= want_up;
        have_last <= 1'b1;
        if (step_now && !sat_hit) tap <= want_up ? tap + 1'b1 : tap - 1'b1;
        if (sat_hit) begin
          alt_cnt <= '0;
          lock_q  <= 1'b0;
        end else if (alternate) begin
          if (int'(alt_cnt) < LOCK_M) alt_cnt <= alt_cnt + 1'b1;
          if (int'(alt_cnt) + 1 >= LOCK_M) lock_q <= 1'b1;
        end else begin
          alt_cnt <= '0;
        end
      end
    end
  end

  assign tap_code = tap;
  assign locked   = lock_q;
  assign qclk     = ph[1] ^ inv_clk;
endmodule

// File: rtl/dll_quad_ctrl_chk.sv
module dll_quad_ctrl_chk #(
  parameter int NEG_TAPS = 8,
  parameter int POS_TAPS = 32,
  localparam int TAP_MAX = NEG_TAPS + POS_TAPS,
  localparam int TW      = $clog2(TAP_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          inv_clk,
  input logic [TW-1:0] tap_code,
  input logic          locked,
  input logic          qclk
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R5
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tap_code) <= TAP_MAX);

  // R8
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tap_code == TW'(NEG_TAPS)) && !locked);

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !$past(restart)) |->
      (tap_code == $past(tap_code) || tap_code == $past(tap_code) + 1'b1 ||
       tap_code + 1'b1 == $past(tap_code)));

  // R2
  qclk_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && inv_clk == $past(inv_clk, 2)) |-> (qclk != $past(qclk, 2)));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $rose(locked)) |-> !$past(restart));
endmodule

bind dll_quad_ctrl dll_quad_ctrl_chk #(.NEG_TAPS(NEG_TAPS), .POS_TAPS(POS_TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .inv_clk(inv_clk),
  .tap_code(tap_code), .locked(locked), .qclk(qclk)
);

// File: tb/dll_quad_ctrl_test.sv
module dll_quad_ctrl_test;
  localparam int NEG = 4, POS = 12, AGN = 3, LKM = 4;
  localparam int TMAX = NEG + POS;
  localparam int TW = $clog2(TMAX + 1);

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, inv_clk = 1'b0, ref_bit = 1'b0;
  logic [TW-1:0] tap_code;
  logic locked, qclk;

  dll_quad_ctrl #(.NEG_TAPS(NEG), .POS_TAPS(POS), .AGREE_N(AGN), .LOCK_M(LKM)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .inv_clk(inv_clk), .ref_bit(ref_bit),
    .tap_code(tap_code), .locked(locked), .qclk(qclk));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_ph = 0, m_s0 = 0, m_tap = NEG, m_cnt = 0, m_dir = 0, m_last = 0, m_have = 0, m_alt = 0, m_lock = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int decide_up(int s0, int s1, int inv);
    int up;
    up = s0;  // R3: codes 11 and 10 add delay
    return up ^ inv;
  endfunction

  task automatic model_edge();
    int up, nxt, step, sat, alt;
    if (m_ph == 1 && !restart) begin
      up   = decide_up(m_s0, int'(ref_bit), int'(inv_clk));
      nxt  = (m_cnt != 0 && m_dir == up) ? m_cnt + 1 : 1;
      step = (nxt == AGN);
      sat  = step && (up ? m_tap == TMAX : m_tap == 0);
      alt  = m_have && (up != m_last);
      m_cnt = step ? 0 : nxt;
      m_dir = up; m_last = up; m_have = 1;
      if (step && !sat) m_tap += up ? 1 : -1;
      if (sat) begin m_alt = 0; m_lock = 0; end
      else if (alt) begin
        if (m_alt < LKM) m_alt++;
        if (m_alt >= LKM) m_lock = 1;
      end else m_alt = 0;
    end else if (restart) begin
      m_tap = NEG; m_cnt = 0; m_dir = 0; m_last = 0; m_have = 0; m_alt = 0; m_lock = 0;
    end
    if (m_ph == 0) m_s0 = int'(ref_bit);
    m_ph = (m_ph + 1) % 4;
  endtask

  // one quarter-rate period with reference phase d (0..3)
  task automatic quarter(int d, int inv, int rs);
    for (int i = 0; i < 4; i++) begin
      restart = rs[0];
      inv_clk = inv[0];
      ref_bit = (((m_ph - d + 4) % 4) < 2);
      if (rs != 0 && ($urandom % 2) == 1) ref_bit = ~ref_bit;  // R8: ignored
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R4 tap_code", int'(tap_code), m_tap);
      chk("R7 locked", int'(locked), m_lock);
      chk("R2 qclk", int'(qclk), ((m_ph >> 1) & 1) ^ inv);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset tap", int'(tap_code), NEG);
    chk("R1 reset lock", int'(locked), 0);
    rst_n = 1'b1;
    chk("R1 released tap", int'(tap_code), NEG);

    // R3 normal: code 11 adds delay; R5 upper saturation
    repeat (4) quarter(0, 0, 0);
    chk("R3 add delay", int'(tap_code), NEG + 1);
    repeat (40) quarter(0, 0, 0);
    chk("R5 top saturation", int'(tap_code), TMAX);

    // R7 dither between codes 11 and 01 gives lock, tap held
    for (int k = 0; k < 8; k++) quarter(k % 2, 0, 0);
    chk("R7 lock after dither", int'(locked), 1);
    chk("R4 tap held while dithering", int'(tap_code), TMAX);

    // R6 saturation clears lock
    repeat (3) quarter(0, 0, 0);
    chk("R6 lock cleared by saturation", int'(locked), 0);

    // R3 invert swaps zones; R5 lower saturation
    repeat (3) quarter(0, 1, 0);
    chk("R3 inverted subtracts", int'(tap_code), TMAX - 1);
    repeat (60) quarter(0, 1, 0);
    chk("R5 bottom saturation", int'(tap_code), 0);

    // R8 restart
    repeat (5) quarter($urandom % 4, 0, 1);
    chk("R8 restart tap", int'(tap_code), NEG);
    chk("R8 restart lock", int'(locked), 0);

    // R4 interrupted runs: two agreeing then a disagreeing one never step
    for (int k = 0; k < 6; k++) begin
      quarter(0, 0, 0); quarter(0, 0, 0); quarter(2, 0, 0);
    end
    chk("R4 no step on broken runs", int'(tap_code), NEG);

    for (int seg = 0; seg < 400; seg++) begin
      int d, inv, rs, len, mode;
      d = $urandom % 4; inv = (($urandom % 5) == 0); rs = (($urandom % 10) == 0);
      len = 1 + $urandom % 8; mode = $urandom % 3;
      for (int q = 0; q < len; q++) quarter(mode == 0 ? (q % 2) + 2 * inv : d, inv, rs);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule